// File: doc/BRIEF.md
# Hi-Hat Percussion Phase and Noise Generator

This block works out, once per audio sample, the 10-bit waveform-table phase index for the hi-hat voice of an FM synthesizer. The index does not come from a plain phase counter. It is chosen from four fixed constants. The choice depends on a few integer bits of two other operators' phase counters, and a pseudo-random noise bit can then override it.

The noise bit comes from a 23-bit shift register. A fractional-rate accumulator advances this register. On each sample strobe the accumulator adds a 16.16 increment. The integer part of the sum sets how many register steps to run, up to a fixed cap, and only the fraction is kept. The steps run one per clock. After the last step the phase is computed from the register LSB and from the operator counters captured at the strobe, and a one-cycle done pulse marks the result.

Top module: `hh_phase_gen`

## Requirements
- R1: While rst_ni is low and after it, before the first strobe, phase_o is 0, done_o is 0 and noise_o is 1, because the noise register resets to 1 and the kept fraction resets to 0.
- R2: On an accepted strobe, sum = kept_fraction + noise_inc_i with 16 fraction bits. The integer part of sum is the step count, and the low 16 bits of sum become the new kept fraction.
- R3: The step count is limited to MAX_STEPS (default 4). Any integer part above that runs MAX_STEPS steps, and the fraction is still kept.
- R4: One noise step: if the register LSB is 1, the register is XORed with 0x800302 (taken over 24 bits). The register is then shifted right by one and truncated to 23 bits.
- R5: noise_o is always the noise register LSB.
- R6: Base phase: with x = bits [31:16] of op7_cnt_i, if (x[2] ^ x[7]) | x[3] the phase is 0x234, otherwise 0x0D0.
- R7: With y = bits [31:16] of op8_cnt_i, if y[3] ^ y[5] the phase is forced to 0x234.
- R8: If the noise bit after the steps is 1, the phase becomes 0x2D0 when bit 9 of the phase so far is 1, and 0x034 when it is 0. With noise 0 the phase is unchanged.
- R9: When the strobe is taken at clock edge E0 and n steps are due, phase_o updates and done_o goes high for exactly one cycle at edge E(n+1).
- R10: A strobe that arrives while a computation is in progress is ignored. It does not change the step count, the fraction, the timing or the result.
- R11: op7_cnt_i and op8_cnt_i are sampled only at the strobe edge. Later changes do not affect that sample's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample strobe |
| noise_inc_i | input | 32 | Noise rate increment, 16.16 |
| op7_cnt_i | input | 32 | Channel-7 operator-1 phase counter, 16.16 |
| op8_cnt_i | input | 32 | Channel-8 operator-2 phase counter, 16.16 |
| phase_o | output | 10 | Hi-hat phase index |
| noise_o | output | 1 | Current noise bit |
| done_o | output | 1 | One-cycle result valid pulse |

## Verification
The result of a strobe that runs n noise steps is due n+1 edges after the strobe edge. The bench drives and samples on falling edges. It counts falling edges from the strobe until done_o is seen and compares that count with n+2, where n comes from its own accumulator model. Phase and noise are compared at that same falling edge, and operator inputs are changed straight after the strobe to show they were captured. A second strobe injected mid-computation must leave both the timing and the model's later samples intact.

// File: rtl/hh_pkg.sv
package hh_pkg;
  localparam int PH_W = 10;
  localparam logic [PH_W-1:0] PH_HI    = 10'h234;
  localparam logic [PH_W-1:0] PH_LO    = 10'h0D0;
  localparam logic [PH_W-1:0] PH_NZ_HI = 10'h2D0;
  localparam logic [PH_W-1:0] PH_NZ_LO = 10'h034;
  localparam logic [23:0]     NOISE_POLY = 24'h800302;
endpackage

// File: rtl/hh_noise_sr.sv
module hh_noise_sr #(
  parameter int W = 23,
  parameter logic [W:0] POLY = hh_pkg::NOISE_POLY[W:0]
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] FB = POLY[W:1];
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= W'(1);
    else if (step_i) q_q <= (q_q >> 1) ^ (q_q[0] ? FB : '0);
  end
  assign q_o = q_q;

  assert_sr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(q_q));
  assert_sr_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);
endmodule

// File: rtl/hh_rate_acc.sv
module hh_rate_acc #(
  parameter int INT_W = 16,
  parameter int FRAC_W = 16,
  parameter int MAX_STEPS = 4,
  localparam int CNT_W = $clog2(MAX_STEPS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [INT_W+FRAC_W-1:0] inc_i,
  output logic [CNT_W-1:0]        steps_o
);
  logic [FRAC_W-1:0]       frac_q;
  logic [INT_W+FRAC_W:0]   sum;
  logic [INT_W:0]          whole;

  assign sum   = {{(INT_W+1){1'b0}}, frac_q} + {1'b0, inc_i};
  assign whole = sum[FRAC_W +: INT_W+1];
  assign steps_o = (whole > (INT_W+1)'(MAX_STEPS)) ? CNT_W'(MAX_STEPS)
                                                  : whole[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   frac_q <= '0;
    else if (en_i) frac_q <= sum[FRAC_W-1:0];
  end

  assert_frac_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(frac_q));
endmodule

// File: rtl/hh_phase_sel.sv
module hh_phase_sel
  import hh_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic [INT_W-1:0] op7_i,
  input  logic [INT_W-1:0] op8_i,
  input  logic             noise_i,
  output logic [PH_W-1:0]  phase_o
);
  logic             res1, force_hi;
  logic [PH_W-1:0]  base;

  always_comb begin
    res1     = (op7_i[2] ^ op7_i[7]) | op7_i[3];
    force_hi = op8_i[3] ^ op8_i[5];
    base     = (res1 || force_hi) ? PH_HI : PH_LO;
    if (noise_i) phase_o = base[9] ? PH_NZ_HI : PH_NZ_LO;
    else         phase_o = base;
  end
endmodule

// File: rtl/hh_phase_gen.sv
module hh_phase_gen
  import hh_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int FRAC_W = 16,
  parameter int NOISE_W = 23,
  parameter int MAX_STEPS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic [INT_W+FRAC_W-1:0] noise_inc_i,
  input  logic [INT_W+FRAC_W-1:0] op7_cnt_i,
  input  logic [INT_W+FRAC_W-1:0] op8_cnt_i,
  output logic [PH_W-1:0]         phase_o,
  output logic                    noise_o,
  output logic                    done_o
);
  localparam int CNT_W = $clog2(MAX_STEPS + 1);

  logic               busy_q, done_q, accept, step;
  logic [CNT_W-1:0]   rem_q, steps;
  logic [INT_W-1:0]   op7_q, op8_q;
  logic [PH_W-1:0]    phase_q, phase_d;
  logic [NOISE_W-1:0] sr;

  assign accept = sample_i && !busy_q;
  assign step   = busy_q && (rem_q != '0);

  hh_rate_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MAX_STEPS(MAX_STEPS)) u_acc (
    .clk_i, .rst_ni, .en_i(accept), .inc_i(noise_inc_i), .steps_o(steps));

  hh_noise_sr #(.W(NOISE_W)) u_sr (
    .clk_i, .rst_ni, .step_i(step), .q_o(sr));

  hh_phase_sel #(.INT_W(INT_W)) u_sel (
    .op7_i(op7_q), .op8_i(op8_q), .noise_i(sr[0]), .phase_o(phase_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      op7_q   <= '0;
      op8_q   <= '0;
      phase_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        rem_q  <= steps;
        op7_q  <= op7_cnt_i[FRAC_W +: INT_W];
        op8_q  <= op8_cnt_i[FRAC_W +: INT_W];
      end else if (busy_q) begin
        if (rem_q != '0) begin
          rem_q <= rem_q - 1'b1;
        end else begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          phase_q <= phase_d;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign noise_o = sr[0];
  assign done_o  = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_steps_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CNT_W'(MAX_STEPS));
  assert_busy_countdown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rem_q != '0) |=> (busy_q && rem_q == $past(rem_q) - 1'b1));
  assert_phase_noise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && noise_o) |-> (phase_q == PH_NZ_HI || phase_q == PH_NZ_LO));
  assert_phase_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_HI || phase_q == PH_LO ||
                phase_q == PH_NZ_HI || phase_q == PH_NZ_LO));
endmodule

// File: tb/hh_phase_gen_tb_top.sv
module hh_phase_gen_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0, sample_i = 1'b0;
  logic [31:0] noise_inc_i = '0, op7_cnt_i = '0, op8_cnt_i = '0;
  logic [9:0]  phase_o;
  logic        noise_o, done_o;

  int checks = 0, fails = 0;
  logic [15:0] frac_m = '0;
  logic [22:0] sr_m = 23'd1;

  always #10 clk_i = ~clk_i;

  hh_phase_gen dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] sr_step(input logic [22:0] r);
    logic [23:0] t;
    t = {1'b0, r};
    if (t[0]) t = t ^ 24'h800302;
    t = t >> 1;
    return t[22:0];
  endfunction

  // one strobe; inject=1 pulses sample_i again mid-computation
  task automatic run(input logic [31:0] inc, input logic [31:0] a, input logic [31:0] b,
                     input bit inject);
    logic [32:0] sum;
    int n, cnt;
    logic [15:0] x, y;
    logic [9:0] ph;
    string tag;
    sum = {17'd0, frac_m} + {1'b0, inc};
    n = int'(sum[32:16]);
    if (n > 4) n = 4;
    frac_m = sum[15:0];
    for (int i = 0; i < n; i++) sr_m = sr_step(sr_m);
    x = a[31:16]; y = b[31:16];
    ph = ((x[2] ^ x[7]) | x[3]) ? 10'h234 : 10'h0D0;
    tag = "R6";
    if (y[3] ^ y[5]) begin ph = 10'h234; tag = "R7"; end
    if (sr_m[0]) begin ph = ph[9] ? 10'h2D0 : 10'h034; tag = "R8"; end

    noise_inc_i = inc; op7_cnt_i = a; op8_cnt_i = b; sample_i = 1'b1;
    @(negedge clk_i);
    sample_i = 1'b0;
    op7_cnt_i = ~a; op8_cnt_i = b ^ 32'h0028_0000; noise_inc_i = 32'h0003_0000; // R11
    cnt = 1;
    while (!done_o && cnt < 20) begin
      if (inject && cnt == 2) sample_i = 1'b1;  // R10
      @(negedge clk_i);
      sample_i = 1'b0;
      cnt++;
    end
    chk(inject ? "R10 timing" : (n == 4 ? "R3 R9 step timing" : "R2 R9 step timing"),
        cnt, n + 2);
    chk({tag, " R11 phase"}, phase_o, ph);
    chk("R5 noise", noise_o, sr_m[0]);
    @(negedge clk_i);
    chk("R9 done single", done_o, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] incs [4];
    incs[0] = 32'h0000_8000; incs[1] = 32'h0001_4000;
    incs[2] = 32'h0007_0000; incs[3] = 32'h0002_C000;
    @(negedge clk_i);
    chk("R1 phase reset", phase_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 noise reset", noise_o, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 noise idle", noise_o, 1);
    chk("R1 done idle", done_o, 0);
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 32; c++) begin
        logic [31:0] a, b;
        a = $urandom & 32'hFF73_FFFF;
        a[18] = c[0]; a[19] = c[1]; a[23] = c[2];
        b = $urandom & 32'hFFD7_FFFF;
        b[19] = c[3]; b[21] = c[4];
        run(incs[k], a, b, 1'b0);
      end
    end
    run(32'h0007_0000, 32'h0004_0000, 32'h0, 1'b1);
    run(32'h0000_0000, 32'h0008_0000, 32'h0008_0000, 1'b0);
    run(32'h0001_0000, 32'h0, 32'h0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule